// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block turns a handful of supply and button indications into the reset that a microcontroller sees, and watches that the software keeps signalling it is alive. A main supply-low indication, already synchronous to the clock, holds the system in reset for as long as it is high. Once it clears, the reset is stretched for a fixed hold time. A raw, active-low push button is synchronised and debounced. While it is pressed it also holds reset, and its release is followed by the same stretch. The reset is driven in both polarities. The early supply warning and two auxiliary supply-fail indications are passed straight through with no delay.

A watchdog counts clock cycles while the system is out of reset. If no kick strobe arrives within the interval picked by a two-bit select, it raises a fault flag. The select comes from a register outside this block that reset does not touch. Three codes choose preset intervals and the fourth switches the watchdog off. The fault stays raised until the next kick. All intervals are parameters counted in clock cycles.

The reset sequencer has three states. RS_HOLD is the reset state: it is left for RS_STRETCH when neither supply-low nor the debounced button is active. RS_STRETCH counts HOLD_CYC cycles. It returns to RS_HOLD if either cause comes back, and it moves to RS_RUN when the count is done. RS_RUN returns to RS_HOLD on either cause. The watchdog has three states. WD_IDLE is forced while reset is active and moves to WD_COUNT on an enabled select. WD_COUNT reloads on a kick, moves to WD_FAULT when the interval expires, and returns to WD_IDLE on the disable code. WD_FAULT moves back to WD_COUNT on a kick and to WD_IDLE on the disable code.

Top module: `sup_reset_ctrl`

## Requirements
- R1: `sys_rst` is 1 in the same cycle that `supply_low` is 1, and stays 1 while it is held.
- R2: After `supply_low` is sampled low, reset stays active for exactly HOLD_CYC more clock edges. This also applies to the first release after `por_n`.
- R3: After the debounced button is released, reset stays active for HOLD_CYC edges. Counted from the raw release, reset is high for STABLE_CYC+2+HOLD_CYC cycles.
- R4: `mr_btn_n` is active low and passes through a two-flop synchroniser. A new level is taken only after it has been stable for STABLE_CYC edges, so reset rises STABLE_CYC+2 cycles after a press. A pulse shorter than STABLE_CYC cycles has no effect.
- R5: `sys_rst_n` is always the inverse of `sys_rst`. After `por_n`, reset is active and the fault flag is 0.
- R6: `supply_early` equals `supply_low` and `aux_fail_out` equals `aux_fail_in`, with no clock delay.
- R7: With `wd_sel` at 0, 1 or 2, the interval is TMO0_CYC, TMO1_CYC or TMO2_CYC. `wd_fault` rises exactly that many cycles after the kick that last restarted the count.
- R8: `wd_sel` = 3 disables the watchdog. `wd_fault` stays 0, and an active fault clears on the next edge.
- R9: The watchdog is held idle with its fault cleared while reset is active. It starts counting on the first edge after reset releases, so the fault rises at interval+1 cycles after the release.
- R10: `wd_fault` stays 1 until a kick, which clears it and restarts the interval. Kicks spaced by at most the interval keep it at 0.
- R11: A return of `supply_low` during the stretch sends the sequencer back to RS_HOLD, and the next release restarts the full hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on clear of the digital state |
| supply_low | input | 1 | Synchronous main supply-low indication, active high |
| mr_btn_n | input | 1 | Raw manual reset button, active low |
| aux_fail_in | input | 2 | Auxiliary supply-fail indications |
| wd_kick | input | 1 | Watchdog restart strobe, one cycle |
| wd_sel | input | 2 | Timeout select from a register outside the block: 0..2 choose an interval, 3 disables |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |
| supply_early | output | 1 | Early low-supply flag |
| aux_fail_out | output | 2 | Auxiliary fail flags passed through |
| wd_fault | output | 1 | Watchdog fault, active high |

## Verification
The bench measures the stretch to the exact cycle after a power-up release, after a release in run, and after a supply return in mid-stretch. A sequencer that does not restart its count would release early, and an off-by-one counter would shift the count by a cycle. It sweeps button pulses of every width below the stable count, which must leave reset low. It also checks the pulse exactly at that width, which must reach reset, so a debouncer with the wrong threshold is caught on one side or the other. For each select code, the fault edge is timed after a kick and after a reset release. A watchdog that counts during reset, or that starts a cycle late, moves that edge. Kicks placed on the last legal cycle must keep the fault at 0, and the disable code must clear a fault that is already set.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        RS_HOLD    = 2'd0,
        RS_STRETCH = 2'd1,
        RS_RUN     = 2'd2
    } rst_state_t;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_FAULT = 2'd2
    } wd_state_t;

    localparam logic [1:0] WD_SEL_OFF = 2'b11;
endpackage

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int STABLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic pressed
);
    localparam int CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic          sync1, sync2;
    logic          level_n;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1   <= 1'b1;
            sync2   <= 1'b1;
            level_n <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync1 <= btn_n;
            sync2 <= sync1;
            if (sync2 == level_n) begin
                run_cnt <= '0;
            end else if (run_cnt == LAST) begin
                level_n <= sync2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign pressed = !level_n;

    // R4: a level is only taken after the full stable run
    a_r4_stable_run: assert property (@(posedge clk) disable iff (!rst_n)
        (level_n != $past(level_n)) |-> ($past(run_cnt) == LAST && $past(sync2) == level_n));
endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq
    import sup_pkg::*;
#(
    parameter int HOLD_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic mr_active,
    output logic rst_act
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    rst_state_t    state, nxt;
    logic [CW-1:0] hold_cnt;
    logic          cause;

    assign cause = supply_low || mr_active;

    always_comb begin
        nxt = state;
        unique case (state)
            RS_HOLD:    nxt = cause ? RS_HOLD : RS_STRETCH;
            RS_STRETCH: begin
                if (cause)                 nxt = RS_HOLD;
                else if (hold_cnt == LAST) nxt = RS_RUN;
                else                       nxt = RS_STRETCH;
            end
            RS_RUN:     nxt = cause ? RS_HOLD : RS_RUN;
            default:    nxt = RS_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RS_HOLD;
            hold_cnt <= '0;
        end else begin
            state    <= nxt;
            hold_cnt <= (state == RS_STRETCH && nxt == RS_STRETCH) ? hold_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        rst_act = cause || (state != RS_RUN);
    end

    // R1: supply-low always shows as reset
    a_r1_supply_forces: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> rst_act);
    // R2 / R3: release only after the full hold count
    a_r2_hold_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && $past(rst_act)) |-> ($past(state) == RS_STRETCH && $past(hold_cnt) == LAST));
    // R11: a cause during the stretch leaves no partial run
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_STRETCH && supply_low) |=> (state == RS_HOLD && hold_cnt == '0));
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int TMO0_CYC = 4,
    parameter int TMO1_CYC = 7,
    parameter int TMO2_CYC = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_act,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       fault
);
    localparam int TMAX = (TMO0_CYC > TMO1_CYC) ?
                          ((TMO0_CYC > TMO2_CYC) ? TMO0_CYC : TMO2_CYC) :
                          ((TMO1_CYC > TMO2_CYC) ? TMO1_CYC : TMO2_CYC);
    localparam int CW = $clog2(TMAX + 1);

    wd_state_t     state, nxt;
    logic [CW-1:0] tick_cnt;
    logic [CW-1:0] lim_m1;
    logic          off;

    assign off = (sel == WD_SEL_OFF);

    always_comb begin
        unique case (sel)
            2'd0:    lim_m1 = CW'(TMO0_CYC - 1);
            2'd1:    lim_m1 = CW'(TMO1_CYC - 1);
            2'd2:    lim_m1 = CW'(TMO2_CYC - 1);
            default: lim_m1 = '0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WD_IDLE:  nxt = off ? WD_IDLE : WD_COUNT;
            WD_COUNT: begin
                if (off)                     nxt = WD_IDLE;
                else if (kick)               nxt = WD_COUNT;
                else if (tick_cnt == lim_m1) nxt = WD_FAULT;
                else                         nxt = WD_COUNT;
            end
            WD_FAULT: begin
                if (off)       nxt = WD_IDLE;
                else if (kick) nxt = WD_COUNT;
                else           nxt = WD_FAULT;
            end
            default:  nxt = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= WD_IDLE;
            tick_cnt <= '0;
        end else if (rst_act) begin
            state    <= WD_IDLE;
            tick_cnt <= '0;
        end else begin
            state    <= nxt;
            tick_cnt <= (state == WD_COUNT && nxt == WD_COUNT && !kick) ? tick_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        fault = (state == WD_FAULT);
    end

    // R7: the fault edge lands on the last count of the selected interval
    a_r7_interval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> ($past(tick_cnt) == $past(lim_m1)));
    // R9: reset clears the watchdog
    a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |=> !fault);
    // R8: the disable code keeps the fault low
    a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> !fault);
    // R10: the fault holds until a kick
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !kick && !off && !rst_act) |=> fault);
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int HOLD_CYC   = 6,
    parameter int STABLE_CYC = 3,
    parameter int TMO0_CYC   = 4,
    parameter int TMO1_CYC   = 7,
    parameter int TMO2_CYC   = 10,
    parameter int AUX_N      = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             supply_low,
    input  logic             mr_btn_n,
    input  logic [AUX_N-1:0] aux_fail_in,
    input  logic             wd_kick,
    input  logic [1:0]       wd_sel,
    output logic             sys_rst,
    output logic             sys_rst_n,
    output logic             supply_early,
    output logic [AUX_N-1:0] aux_fail_out,
    output logic             wd_fault
);
    logic mr_active;
    logic rst_act;

    sup_debounce #(.STABLE_CYC(STABLE_CYC)) u_deb (
        .clk     (clk),
        .rst_n   (por_n),
        .btn_n   (mr_btn_n),
        .pressed (mr_active)
    );

    sup_rst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (por_n),
        .supply_low (supply_low),
        .mr_active  (mr_active),
        .rst_act    (rst_act)
    );

    sup_watchdog #(
        .TMO0_CYC (TMO0_CYC),
        .TMO1_CYC (TMO1_CYC),
        .TMO2_CYC (TMO2_CYC)
    ) u_wd (
        .clk     (clk),
        .rst_n   (por_n),
        .rst_act (rst_act),
        .kick    (wd_kick),
        .sel     (wd_sel),
        .fault   (wd_fault)
    );

    assign sys_rst      = rst_act;
    assign sys_rst_n    = !rst_act;
    assign supply_early = supply_low;

    for (genvar g = 0; g < AUX_N; g++) begin : g_aux
        assign aux_fail_out[g] = aux_fail_in[g];
    end

    // R3: the button holds reset while its debounced level is active
    a_r3_button_holds: assert property (@(posedge clk) disable iff (!por_n)
        mr_active |-> sys_rst);
endmodule

// File: tb/sup_reset_ctrl_test.sv
`timescale 1ns/1ps
module sup_reset_ctrl_test;
    localparam int HOLD = 6;
    localparam int DEB  = 3;
    localparam int T0   = 4;
    localparam int T1   = 7;
    localparam int T2   = 10;

    logic       clk = 1'b0;
    logic       por_n;
    logic       supply_low;
    logic       mr_btn_n;
    logic [1:0] aux_fail_in;
    logic       wd_kick;
    logic [1:0] wd_sel;
    logic       sys_rst, sys_rst_n, supply_early, wd_fault;
    logic [1:0] aux_fail_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sup_reset_ctrl #(
        .HOLD_CYC(HOLD), .STABLE_CYC(DEB),
        .TMO0_CYC(T0), .TMO1_CYC(T1), .TMO2_CYC(T2), .AUX_N(2)
    ) uut (
        .clk(clk), .por_n(por_n), .supply_low(supply_low), .mr_btn_n(mr_btn_n),
        .aux_fail_in(aux_fail_in), .wd_kick(wd_kick), .wd_sel(wd_sel),
        .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .supply_early(supply_early),
        .aux_fail_out(aux_fail_out), .wd_fault(wd_fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lim_of(input int s);
        return (s == 0) ? T0 : (s == 1) ? T1 : T2;
    endfunction

    // count cycles with reset still high, starting at the current negedge
    task automatic count_rst(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            chk(sys_rst_n == !sys_rst, "R5", sys_rst_n, !sys_rst);
            if (!sys_rst || n > 200) break;
            n++;
        end
    endtask

    task automatic count_wd(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (wd_fault || n > 200) break;
        end
    endtask

    task automatic kick();
        @(negedge clk) wd_kick = 1'b1;
        @(negedge clk) wd_kick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        por_n = 1'b0; supply_low = 1'b1; mr_btn_n = 1'b1;
        aux_fail_in = 2'b00; wd_kick = 1'b0; wd_sel = 2'b11;
        repeat (3) @(negedge clk);
        // R5: reset state
        chk(sys_rst == 1'b1, "R5", sys_rst, 1);
        chk(sys_rst_n == 1'b0, "R5", sys_rst_n, 0);
        chk(wd_fault == 1'b0, "R5", wd_fault, 0);
        por_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sys_rst == 1'b1, "R1", sys_rst, 1);
        // R2: power-up stretch
        supply_low = 1'b0;
        count_rst(n);
        chk(n == HOLD, "R2", n, HOLD);

        // R1: immediate assertion in run
        @(negedge clk) supply_low = 1'b1;
        #1 chk(sys_rst == 1'b1, "R1", sys_rst, 1);
        repeat (2) @(negedge clk);
        chk(sys_rst == 1'b1, "R1", sys_rst, 1);
        supply_low = 1'b0;
        count_rst(n);
        chk(n == HOLD, "R2", n, HOLD);

        // R11: supply returns in mid-stretch
        @(negedge clk) supply_low = 1'b1;
        @(negedge clk) supply_low = 1'b0;
        repeat (3) @(negedge clk);
        chk(sys_rst == 1'b1, "R11", sys_rst, 1);
        supply_low = 1'b1;
        @(negedge clk) supply_low = 1'b0;
        count_rst(n);
        chk(n == HOLD, "R11", n, HOLD);

        // R6: pass-through sweep
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            aux_fail_in = v[1:0];
            supply_low  = v[2];
            #1;
            chk(aux_fail_out == v[1:0], "R6", aux_fail_out, v[1:0]);
            chk(supply_early == v[2], "R6", supply_early, v[2]);
        end
        supply_low = 1'b0;
        aux_fail_in = 2'b00;
        count_rst(n);

        // R4: pulses shorter than the stable count are ignored
        for (int w = 1; w < DEB; w++) begin
            @(negedge clk) mr_btn_n = 1'b0;
            repeat (w - 1) @(negedge clk);
            @(negedge clk) mr_btn_n = 1'b1;
            for (int k = 0; k < DEB + 6; k++) begin
                @(negedge clk);
                chk(sys_rst == 1'b0, "R4", sys_rst, 0);
            end
        end
        // R4: pulse of exactly the stable count is taken
        begin
            bit seen = 0;
            @(negedge clk) mr_btn_n = 1'b0;
            repeat (DEB - 1) @(negedge clk);
            @(negedge clk) mr_btn_n = 1'b1;
            for (int k = 0; k < DEB + 4; k++) begin
                @(negedge clk);
                if (sys_rst) seen = 1;
            end
            chk(seen, "R4", seen, 1);
            count_rst(n);
        end
        // R4: press latency
        @(negedge clk) mr_btn_n = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (sys_rst || n > 200) break;
        end
        chk(n == DEB + 2, "R4", n, DEB + 2);
        repeat (8) @(negedge clk);
        chk(sys_rst == 1'b1, "R3", sys_rst, 1);
        // R3: release stretch
        mr_btn_n = 1'b1;
        count_rst(n);
        chk(n == DEB + 2 + HOLD, "R3", n, DEB + 2 + HOLD);

        // R7 / R10: each interval, stickiness, clearing and just-in-time kicks
        for (int s = 0; s < 3; s++) begin
            wd_sel = s[1:0];
            kick();
            count_wd(n);
            chk(n == lim_of(s), "R7", n, lim_of(s));
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk(wd_fault == 1'b1, "R10", wd_fault, 1);
            end
            kick();
            chk(wd_fault == 1'b0, "R10", wd_fault, 0);
            for (int r = 0; r < 4; r++) begin
                for (int k = 0; k < lim_of(s) - 2; k++) begin
                    @(negedge clk);
                    chk(wd_fault == 1'b0, "R10", wd_fault, 0);
                end
                kick();
                chk(wd_fault == 1'b0, "R10", wd_fault, 0);
            end
        end

        // R9: reset clears a fault, count starts the edge after release
        wd_sel = 2'd0;
        kick();
        count_wd(n);
        @(negedge clk) supply_low = 1'b1;
        @(negedge clk);
        chk(wd_fault == 1'b0, "R9", wd_fault, 0);
        supply_low = 1'b0;
        count_rst(n);
        count_wd(n);
        chk(n == T0 + 1, "R9", n, T0 + 1);

        // R8: disable code clears a fault and keeps it low
        @(negedge clk) wd_sel = 2'b11;
        @(negedge clk);
        chk(wd_fault == 1'b0, "R8", wd_fault, 0);
        kick();
        for (int k = 0; k < 3 * T2; k++) begin
            @(negedge clk);
            chk(wd_fault == 1'b0, "R8", wd_fault, 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule